// File: doc/BRIEF.md
# Serial Controller Operating-Mode Register

This block holds the control word of a two-wire serial controller that can also run a clocked synchronous serial format. Software writes and reads the word over a plain register interface. The word carries five fields: a module enable, a reception block, a master select, a transmit select and a four-bit clock-rate code.

Protocol logic outside this block reports events as one-cycle pulses: arbitration loss, a slave address match with its direction bit, an overrun, and a read of the receive data register. The block reacts by forcing the master and transmit bits, so the operating mode can change without software. If software writes in the same cycle as an event, the event still wins for the bits it forces.

From the stored word the block drives the pin-drive enable, a receive-permit flag, the clock-output enable for the synchronous format, the current two-bit mode, and the clock-rate code for an external divider.

Top module: `mode_ctl_top`

## Requirements
- R1: After reset every field of the control word reads 0. `mode`, `clk_sel`, `pin_drive_en`, `clk_out_en` and `rx_permit` are then all 0.
- R2: Bit 7 of the word is the enable. When it is 0, `pin_drive_en`, `clk_out_en` and `rx_permit` are 0. When it is 1, `pin_drive_en` is 1.
- R3: `mode` reflects bit 5 (master) and bit 4 (transmit) as {master, transmit}. The codes are 00 slave receive, 01 slave transmit, 10 master receive and 11 master transmit.
- R4: With `fmt_sync`=0, an `arb_lost` pulse while master is 1 clears both master and transmit in the next cycle. An `arb_lost` pulse has no effect while master is 0.
- R5: With `fmt_sync`=0 and mode 00, an `addr_match` pulse with `addr_rw`=1 sets transmit in the next cycle. With `addr_rw`=0 it has no effect.
- R6: With `fmt_sync`=1, an `overrun` pulse in mode 10 clears master in the next cycle. In any other mode it has no effect.
- R7: `arb_lost` has no effect when `fmt_sync`=1. `overrun` has no effect when `fmt_sync`=0.
- R8: `clk_out_en` is 1 exactly when enable, `fmt_sync` and master are all 1.
- R9: Bits 3..0 of the word appear on `clk_sel` and never change the mode.
- R10: A write (`wr_en`=1) loads `wr_data` into the word on the clock edge. `rd_data` always shows the current word, including bits that hardware has changed.
- R11: When an event acts in the same cycle as a write, the bits it forces take the forced value. The remaining bits take the written value.
- R12: Bit 6 is the reception block. An `rx_read` pulse while enable is 1, transmit is 0 and bit 6 is 1 drops `rx_permit` from the next cycle on. `rx_permit` returns to 1 once bit 6 is 0, while enable is 1 and transmit is 0. In transmit mode `rx_permit` is 0.
- R13: While enable is 0, event pulses leave the word unchanged.
- R14: Event conditions are judged on the word held before the clock edge, not on the value being written in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current control word |
| fmt_sync | input | 1 | 1 selects the clocked synchronous format, 0 the two-wire bus format |
| arb_lost | input | 1 | Arbitration-loss pulse |
| addr_match | input | 1 | Slave address match pulse |
| addr_rw | input | 1 | Direction bit accompanying the address match (1 = read request) |
| overrun | input | 1 | Overrun pulse |
| rx_read | input | 1 | Receive data register read pulse |
| pin_drive_en | output | 1 | Bus pins driven by the controller |
| rx_permit | output | 1 | Next reception allowed |
| clk_out_en | output | 1 | Serial clock output enable |
| mode | output | 2 | {master, transmit} operating mode |
| clk_sel | output | 4 | Clock-rate code for the external divider |

## Verification
The bench places events in the same cycle as software writes. A design that let the write win would leave the block in master mode after a lost arbitration. It also sends events in the wrong format, in the wrong mode and with enable off. A design with loose gating would drop out of master mode on an overrun in bus format, or change mode while halted. One overrun arrives together with a write into master receive mode. The mode must come from the stored word, so a design that judged the written value would clear master wrongly. The reception-block sequence checks that the permit flag falls only after a receive read and rises again once the block bit is cleared.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;

    localparam int CKS_W = 4;
    localparam int REG_W = CKS_W + 4;

    typedef struct packed {
        logic             en;
        logic             rx_block;
        logic             master;
        logic             xmit;
        logic [CKS_W-1:0] rate;
    } ctl_word_t;

    typedef enum logic [1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_RX = 2'b10,
        MODE_MST_TX = 2'b11
    } op_mode_e;

    typedef struct packed {
        logic clr_master;
        logic clr_xmit;
        logic set_xmit;
    } hw_force_t;

    function automatic op_mode_e word_mode(input ctl_word_t w);
        return op_mode_e'({w.master, w.xmit});
    endfunction

    function automatic ctl_word_t apply_force(input ctl_word_t w, input hw_force_t f);
        ctl_word_t r;
        r = w;
        if (f.clr_master) r.master = 1'b0;
        if (f.clr_xmit)   r.xmit   = 1'b0;
        if (f.set_xmit)   r.xmit   = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/mode_ctl_event.sv
module mode_ctl_event
    import mode_ctl_pkg::*;
(
    input  ctl_word_t cur,
    input  logic      fmt_sync,
    input  logic      arb_lost,
    input  logic      addr_match,
    input  logic      addr_rw,
    input  logic      overrun,
    output hw_force_t force_o
);
    op_mode_e  m;
    logic      arb_hit;
    logic      ovr_hit;
    logic      match_hit;

    always_comb begin
        m         = word_mode(cur);
        arb_hit   = cur.en && !fmt_sync && arb_lost && cur.master;
        ovr_hit   = cur.en && fmt_sync && overrun && (m == MODE_MST_RX);
        match_hit = cur.en && !fmt_sync && addr_match && addr_rw && (m == MODE_SLV_RX);

        force_o.clr_master = arb_hit || ovr_hit;
        force_o.clr_xmit   = arb_hit;
        force_o.set_xmit   = match_hit;
    end
endmodule

// File: rtl/mode_ctl_reg.sv
module mode_ctl_reg
    import mode_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  hw_force_t        force_i,
    output ctl_word_t        word_q
);
    ctl_word_t base;
    ctl_word_t word_d;

    always_comb begin
        base   = wr_en ? ctl_word_t'(wr_data) : word_q;
        word_d = apply_force(base, force_i);
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end
endmodule

// File: rtl/mode_ctl_rxgate.sv
module mode_ctl_rxgate
    import mode_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_word_t cur,
    input  logic      rx_read,
    output logic      rx_permit
);
    logic hold_q;
    logic rx_side;

    assign rx_side = cur.en && !cur.xmit;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else if (!rx_side || !cur.rx_block)
            hold_q <= 1'b0;
        else if (rx_read)
            hold_q <= 1'b1;
    end

    assign rx_permit = rx_side && !(hold_q && cur.rx_block);
endmodule

// File: rtl/mode_ctl_top.sv
module mode_ctl_top
    import mode_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             fmt_sync,
    input  logic             arb_lost,
    input  logic             addr_match,
    input  logic             addr_rw,
    input  logic             overrun,
    input  logic             rx_read,
    output logic             pin_drive_en,
    output logic             rx_permit,
    output logic             clk_out_en,
    output logic [1:0]       mode,
    output logic [CKS_W-1:0] clk_sel
);
    ctl_word_t word_q;
    hw_force_t force_w;

    mode_ctl_event u_event (
        .cur        (word_q),
        .fmt_sync   (fmt_sync),
        .arb_lost   (arb_lost),
        .addr_match (addr_match),
        .addr_rw    (addr_rw),
        .overrun    (overrun),
        .force_o    (force_w)
    );

    mode_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .force_i (force_w),
        .word_q  (word_q)
    );

    mode_ctl_rxgate u_rx (
        .clk       (clk),
        .rst       (rst),
        .cur       (word_q),
        .rx_read   (rx_read),
        .rx_permit (rx_permit)
    );

    assign rd_data      = word_q;
    assign pin_drive_en = word_q.en;
    assign clk_out_en   = word_q.en && fmt_sync && word_q.master;
    assign mode         = word_mode(word_q);
    assign clk_sel      = word_q.rate;
endmodule

// File: rtl/mode_ctl_chk.sv
module mode_ctl_chk
    import mode_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             fmt_sync,
    input logic             arb_lost,
    input logic             addr_match,
    input logic             addr_rw,
    input logic             overrun,
    input logic             pin_drive_en,
    input logic             rx_permit,
    input logic             clk_out_en,
    input logic [1:0]       mode
);
    logic en_q;
    logic any_evt;
    assign en_q    = rd_data[REG_W-1];
    assign any_evt = arb_lost || addr_match || overrun;

    a_r2_halted_outputs: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (!pin_drive_en && !clk_out_en && !rx_permit));

    a_r4_arb_to_slave: assert property (@(posedge clk) disable iff (rst)
        (en_q && !fmt_sync && arb_lost && mode[1]) |=> (mode == 2'b00));

    a_r5_match_sets_tx: assert property (@(posedge clk) disable iff (rst)
        (en_q && !fmt_sync && addr_match && addr_rw && mode == 2'b00) |=> mode[0]);

    a_r6_overrun_drops_master: assert property (@(posedge clk) disable iff (rst)
        (en_q && fmt_sync && overrun && mode == 2'b10) |=> !mode[1]);

    a_r8_no_clock_in_bus_format: assert property (@(posedge clk) disable iff (rst)
        !fmt_sync |-> !clk_out_en);

    a_r10_plain_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(en_q && any_evt)) |=> (rd_data == $past(wr_data)));

    a_r11_event_beats_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && en_q && !fmt_sync && arb_lost && mode[1]) |=> (mode == 2'b00));

    a_r13_halted_hold: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !wr_en) |=> $stable(rd_data));
endmodule

bind mode_ctl_top mode_ctl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .fmt_sync     (fmt_sync),
    .arb_lost     (arb_lost),
    .addr_match   (addr_match),
    .addr_rw      (addr_rw),
    .overrun      (overrun),
    .pin_drive_en (pin_drive_en),
    .rx_permit    (rx_permit),
    .clk_out_en   (clk_out_en),
    .mode         (mode)
);

// File: tb/mode_ctl_top_tb_top.sv
module mode_ctl_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       fmt_sync = 1'b0;
    logic       arb_lost = 1'b0;
    logic       addr_match = 1'b0;
    logic       addr_rw = 1'b0;
    logic       overrun = 1'b0;
    logic       rx_read = 1'b0;
    logic       pin_drive_en, rx_permit, clk_out_en;
    logic [1:0] mode;
    logic [3:0] clk_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_ctl_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .fmt_sync(fmt_sync), .arb_lost(arb_lost), .addr_match(addr_match),
        .addr_rw(addr_rw), .overrun(overrun), .rx_read(rx_read),
        .pin_drive_en(pin_drive_en), .rx_permit(rx_permit), .clk_out_en(clk_out_en),
        .mode(mode), .clk_sel(clk_sel)
    );

    // entry: {wr_en, wr_data, fmt_sync, arb_lost, addr_match, addr_rw, overrun, rx_read,
    //         expected rd_data, expected rx_permit, expected clk_out_en}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'h85, 6'b000000, 8'h85, 1'b1, 1'b0}, // 0  R10 R9 write, rate code 5
        {1'b1, 8'hB5, 6'b000000, 8'hB5, 1'b0, 1'b0}, // 1  R3 master transmit
        {1'b0, 8'h00, 6'b010000, 8'h85, 1'b1, 1'b0}, // 2  R4 arbitration lost
        {1'b0, 8'h00, 6'b010000, 8'h85, 1'b1, 1'b0}, // 3  R4 no effect as slave
        {1'b0, 8'h00, 6'b001100, 8'h95, 1'b0, 1'b0}, // 4  R5 match with read request
        {1'b1, 8'h85, 6'b000000, 8'h85, 1'b1, 1'b0}, // 5  R10
        {1'b0, 8'h00, 6'b001000, 8'h85, 1'b1, 1'b0}, // 6  R5 match with write request
        {1'b1, 8'hA5, 6'b000000, 8'hA5, 1'b1, 1'b0}, // 7  R8 bus format, no clock out
        {1'b0, 8'h00, 6'b000010, 8'hA5, 1'b1, 1'b0}, // 8  R7 overrun ignored in bus format
        {1'b1, 8'hA5, 6'b100000, 8'hA5, 1'b1, 1'b1}, // 9  R8 sync format clock out
        {1'b0, 8'h00, 6'b110000, 8'hA5, 1'b1, 1'b1}, // 10 R7 arb loss ignored in sync
        {1'b0, 8'h00, 6'b100010, 8'h85, 1'b1, 1'b0}, // 11 R6 overrun drops master
        {1'b1, 8'hA5, 6'b100010, 8'hA5, 1'b1, 1'b1}, // 12 R14 overrun judged on old word
        {1'b1, 8'hB3, 6'b100010, 8'h93, 1'b0, 1'b0}, // 13 R11 overrun beats write
        {1'b1, 8'hF0, 6'b000000, 8'hF0, 1'b0, 1'b0}, // 14 R12 transmit blocks permit
        {1'b1, 8'hF0, 6'b010000, 8'hC0, 1'b1, 1'b0}, // 15 R11 arb loss beats write
        {1'b0, 8'h00, 6'b000001, 8'hC0, 1'b0, 1'b0}, // 16 R12 read with block set
        {1'b1, 8'h80, 6'b000000, 8'h80, 1'b1, 1'b0}, // 17 R12 block cleared
        {1'b0, 8'h00, 6'b000001, 8'h80, 1'b1, 1'b0}, // 18 R12 read with block clear
        {1'b1, 8'h00, 6'b000000, 8'h00, 1'b0, 1'b0}, // 19 R2 halted
        {1'b0, 8'h00, 6'b001100, 8'h00, 1'b0, 1'b0}, // 20 R13 match ignored while halted
        {1'b1, 8'h30, 6'b000000, 8'h30, 1'b0, 1'b0}, // 21 R2 halted master
        {1'b0, 8'h00, 6'b010000, 8'h30, 1'b0, 1'b0}, // 22 R13 arb ignored while halted
        {1'b1, 8'h20, 6'b100000, 8'h20, 1'b0, 1'b0}, // 23 R2 no clock while halted
        {1'b0, 8'h00, 6'b100010, 8'h20, 1'b0, 1'b0}  // 24 R13 overrun ignored while halted
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_word(input string tag, input logic [7:0] w, input bit p, input bit c);
        chk({tag, " rd_data"},  rd_data, w);
        chk({tag, " rx_permit"}, rx_permit, p);
        chk({tag, " clk_out_en"}, clk_out_en, c);
        chk({tag, " mode R3"}, mode, w[5:4]);
        chk({tag, " pin_drive_en R2"}, pin_drive_en, w[7]);
        chk({tag, " clk_sel R9"}, clk_sel, w[3:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_word("R1 reset", 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            {wr_en, wr_data, fmt_sync, arb_lost, addr_match, addr_rw, overrun, rx_read} = VEC[i][24:10];
            @(negedge clk);
            chk_word($sformatf("vector %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R1 reset after a full word
        {wr_en, wr_data, fmt_sync, arb_lost, addr_match, addr_rw, overrun, rx_read} = {1'b1, 8'hFF, 6'b100000};
        @(negedge clk);
        chk("R10 full word", rd_data, 8'hFF);
        wr_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_word("R1 reset again", 8'h00, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule